// File: doc/BRIEF.md
# Day and Time-of-Day Real-Time Clock with Alarm

This block keeps calendar-free wall time as a 15-bit day number plus a seconds-of-day count. It advances once for each pulse on a one-second tick input. Seconds-of-day is visible as two narrow fields: an 8-bit low part and a 9-bit high part. A second set of three fields holds an alarm instant. The block flags an alarm when the running time first equals that instant. It also flags every tick and every wrap of the day number.

Software reaches all fields over a single-cycle register port. Writes are synchronous and reads are combinational from the selected address. The block holds no snapshot latch. Software therefore gets a consistent view through an ordering protocol. To set the time, it zeroes the low field, then writes the day, the high field and finally the low field. To read the time, it reads high, day, low, then high again, and re-reads the day if the high field went down. Three sticky status bits, each with an enable bit, merge into one interrupt line.

Top module: `tod_rtc`

## Requirements
- R1: Each tick advances seconds-of-day by one. A tick taken while seconds-of-day is 86399 or more returns it to 0 and adds one to the day. Without a tick or a write, the time holds.
- R2: Word addresses are 0 day, 1 seconds bits 7:0, 2 seconds bits 16:8, 3 alarm day, 4 alarm seconds 7:0, 5 alarm seconds 16:8, 6 status, 7 enable. The read data reflects the addressed register in the same cycle. A write is visible from the next cycle.
- R3: A write keeps only the field width: 15 bits for either day, 8 bits for either low field, 9 bits for either high field and 3 bits for status and enable. The bits above the field are dropped and read back as zero.
- R4: When a write and a tick fall in the same cycle, the written register takes the written value. The other time registers take their ticked values, carry included.
- R5: A day-advancing tick at day 32767 sets the day to 0 and sets status bit 2 (day wrap).
- R6: Status bit 0 (alarm) is set one cycle after the time registers first become equal to all three alarm registers. It is not set again while the equality persists.
- R7: Every tick sets status bit 1 (second tick) in the same edge.
- R8: Writing status clears each bit written as 1. An event arriving in the same cycle keeps its bit set.
- R9: irq_o is high exactly when some status bit and the enable bit at the same position are both 1.
- R10: The time fields hold live values with no snapshot. After the low field is set to 0, writing day, high and then low, with ticks between the writes, yields exactly the written time. The read order high, day, low, high exposes a carry taken partway through the sequence.
- R11: After reset every register reads 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 3 | Register word address |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data of the addressed register |
| irq_o | output | 1 | Merged interrupt |

## Verification
On every cycle, the assertions check the local arithmetic of the counter. They cover the single-step increment and the wrap at the end of the day, holding still when idle, the day-wrap flag, and the precedence of a low-field write over a tick. They also check that a tick sets its status bit and raises the interrupt when enabled. Some behaviour shows up only in the bench's scenarios. This covers the alarm edge detection across several cycles and write-one-to-clear racing an event. It also covers the ordered set and read protocols, which run across ticks, and the field masking seen through reads. A cycle model in the bench follows the time, alarm and status under random ticks and writes.

// File: rtl/tod_rtc_pkg.sv
package tod_rtc_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_DAY  = 3'd0,
        A_LO   = 3'd1,
        A_HI   = 3'd2,
        A_ADAY = 3'd3,
        A_ALO  = 3'd4,
        A_AHI  = 3'd5,
        A_STS  = 3'd6,
        A_EN   = 3'd7
    } reg_addr_e;

    localparam int ST_ALM  = 0;
    localparam int ST_TICK = 1;
    localparam int ST_OVF  = 2;
    localparam int NUM_SRC = 3;

endpackage

// File: rtl/tod_counter.sv
module tod_counter #(
    parameter int DAY_W       = 15,
    parameter int LO_W        = 8,
    parameter int HI_W        = 9,
    parameter int SEC_PER_DAY = 86400
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wr_day_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [DAY_W-1:0] day_wr_i,
    input  logic [LO_W-1:0]  lo_wr_i,
    input  logic [HI_W-1:0]  hi_wr_i,
    output logic [DAY_W-1:0] day_o,
    output logic [LO_W-1:0]  lo_o,
    output logic [HI_W-1:0]  hi_o,
    output logic             day_wrap_o
);
    localparam int SEC_W    = LO_W + HI_W;
    localparam int LAST_SEC = SEC_PER_DAY - 1;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HI_W-1:0]  hi;
        logic [LO_W-1:0]  lo;
    } tod_t;

    tod_t cur_q, nxt_d;
    logic [SEC_W-1:0] secs, secs_step;
    logic [DAY_W-1:0] day_step;

    always_comb begin
        secs       = {cur_q.hi, cur_q.lo};
        secs_step  = secs;
        day_step   = cur_q.day;
        day_wrap_o = 1'b0;
        if (tick_i) begin
            if (secs >= SEC_W'(LAST_SEC)) begin
                secs_step  = '0;
                day_step   = cur_q.day + 1'b1;
                day_wrap_o = (cur_q.day == '1);
            end else begin
                secs_step  = secs + 1'b1;
            end
        end
        // a written field overrides its own ticked value only (R4)
        nxt_d.day = wr_day_i ? day_wr_i : day_step;
        nxt_d.lo  = wr_lo_i  ? lo_wr_i  : secs_step[LO_W-1:0];
        nxt_d.hi  = wr_hi_i  ? hi_wr_i  : secs_step[SEC_W-1:LO_W];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign day_o = cur_q.day;
    assign lo_o  = cur_q.lo;
    assign hi_o  = cur_q.hi;
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm #(
    parameter int DAY_W = 15,
    parameter int LO_W  = 8,
    parameter int HI_W  = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_day_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [DAY_W-1:0] day_wr_i,
    input  logic [LO_W-1:0]  lo_wr_i,
    input  logic [HI_W-1:0]  hi_wr_i,
    input  logic [DAY_W-1:0] now_day_i,
    input  logic [LO_W-1:0]  now_lo_i,
    input  logic [HI_W-1:0]  now_hi_i,
    output logic [DAY_W-1:0] day_o,
    output logic [LO_W-1:0]  lo_o,
    output logic [HI_W-1:0]  hi_o,
    output logic             hit_evt_o
);
    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HI_W-1:0]  hi;
        logic [LO_W-1:0]  lo;
        logic             hit;
    } alm_t;

    alm_t cur_q, nxt_d;
    logic hit_now;

    always_comb begin
        nxt_d   = cur_q;
        hit_now = (now_day_i == cur_q.day) && (now_hi_i == cur_q.hi)
               && (now_lo_i == cur_q.lo);
        if (wr_day_i) nxt_d.day = day_wr_i;
        if (wr_lo_i)  nxt_d.lo  = lo_wr_i;
        if (wr_hi_i)  nxt_d.hi  = hi_wr_i;
        nxt_d.hit = hit_now;
        // only the first cycle of equality is an event (R6)
        hit_evt_o = hit_now && !cur_q.hit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q     <= '0;
            cur_q.hit <= 1'b1; // reset values already match; not an event
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign day_o = cur_q.day;
    assign lo_o  = cur_q.lo;
    assign hi_o  = cur_q.hi;
endmodule

// File: rtl/tod_irq_ctrl.sv
module tod_irq_ctrl #(
    parameter int NSRC = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] evt_i,
    input  logic            wr_clr_i,
    input  logic            wr_en_i,
    input  logic [NSRC-1:0] data_i,
    output logic [NSRC-1:0] sts_o,
    output logic [NSRC-1:0] en_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] sts;
        logic [NSRC-1:0] en;
    } irq_t;

    irq_t cur_q, nxt_d;
    logic [NSRC-1:0] clr_mask;

    always_comb begin
        clr_mask  = wr_clr_i ? data_i : '0;
        nxt_d.sts = (cur_q.sts & ~clr_mask) | evt_i; // set beats clear (R8)
        nxt_d.en  = wr_en_i ? data_i : cur_q.en;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign sts_o = cur_q.sts;
    assign en_o  = cur_q.en;
    assign irq_o = |(cur_q.sts & cur_q.en);
endmodule

// File: rtl/tod_rtc.sv
module tod_rtc
    import tod_rtc_pkg::*;
#(
    parameter int DAY_W       = 15,
    parameter int LO_W        = 8,
    parameter int HI_W        = 9,
    parameter int SEC_PER_DAY = 86400,
    parameter int DATA_W      = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic [DAY_W-1:0]   day_w, aday_w;
    logic [LO_W-1:0]    lo_w, alo_w;
    logic [HI_W-1:0]    hi_w, ahi_w;
    logic [NUM_SRC-1:0] sts_w, en_w, evt_w;
    logic               day_wrap_w, alm_evt_w;
    logic [7:0]         wsel;
    logic               wr_data_unused;

    assign wr_data_unused = ^wr_data_i;

    for (genvar g = 0; g < 8; g++) begin : g_wsel
        assign wsel[g] = wr_en_i && (addr_i == REG_AW'(g));
    end

    tod_counter #(
        .DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W), .SEC_PER_DAY(SEC_PER_DAY)
    ) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
        .wr_day_i(wsel[A_DAY]), .wr_lo_i(wsel[A_LO]), .wr_hi_i(wsel[A_HI]),
        .day_wr_i(wr_data_i[DAY_W-1:0]), .lo_wr_i(wr_data_i[LO_W-1:0]),
        .hi_wr_i(wr_data_i[HI_W-1:0]),
        .day_o(day_w), .lo_o(lo_w), .hi_o(hi_w), .day_wrap_o(day_wrap_w)
    );

    tod_alarm #(
        .DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W)
    ) u_alm (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_day_i(wsel[A_ADAY]), .wr_lo_i(wsel[A_ALO]), .wr_hi_i(wsel[A_AHI]),
        .day_wr_i(wr_data_i[DAY_W-1:0]), .lo_wr_i(wr_data_i[LO_W-1:0]),
        .hi_wr_i(wr_data_i[HI_W-1:0]),
        .now_day_i(day_w), .now_lo_i(lo_w), .now_hi_i(hi_w),
        .day_o(aday_w), .lo_o(alo_w), .hi_o(ahi_w), .hit_evt_o(alm_evt_w)
    );

    always_comb begin
        evt_w          = '0;
        evt_w[ST_ALM]  = alm_evt_w;
        evt_w[ST_TICK] = tick_i;
        evt_w[ST_OVF]  = day_wrap_w;
    end

    tod_irq_ctrl #(.NSRC(NUM_SRC)) u_irq (
        .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_w),
        .wr_clr_i(wsel[A_STS]), .wr_en_i(wsel[A_EN]),
        .data_i(wr_data_i[NUM_SRC-1:0]),
        .sts_o(sts_w), .en_o(en_w), .irq_o(irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        case (reg_addr_e'(addr_i))
            A_DAY:   rd_data_o[DAY_W-1:0]   = day_w;
            A_LO:    rd_data_o[LO_W-1:0]    = lo_w;
            A_HI:    rd_data_o[HI_W-1:0]    = hi_w;
            A_ADAY:  rd_data_o[DAY_W-1:0]   = aday_w;
            A_ALO:   rd_data_o[LO_W-1:0]    = alo_w;
            A_AHI:   rd_data_o[HI_W-1:0]    = ahi_w;
            A_STS:   rd_data_o[NUM_SRC-1:0] = sts_w;
            A_EN:    rd_data_o[NUM_SRC-1:0] = en_w;
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/tod_rtc_chk.sv
module tod_rtc_chk
    import tod_rtc_pkg::*;
#(
    parameter int DAY_W       = 15,
    parameter int LO_W        = 8,
    parameter int HI_W        = 9,
    parameter int SEC_PER_DAY = 86400
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [REG_AW-1:0] addr_i,
    input logic [LO_W-1:0]   lo_data_i,
    input logic              irq_o,
    input logic [DAY_W-1:0]  day_i,
    input logic [LO_W-1:0]   lo_i,
    input logic [HI_W-1:0]   hi_i,
    input logic              tick_sts_i,
    input logic              ovf_sts_i,
    input logic              tick_en_i
);
    localparam int SEC_W    = LO_W + HI_W;
    localparam int LAST_SEC = SEC_PER_DAY - 1;

    logic [SEC_W-1:0] secs;
    assign secs = {hi_i, lo_i};

    AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !wr_en_i && secs < SEC_W'(LAST_SEC))
        |=> (secs == SEC_W'($past(secs) + 1'b1)) && $stable(day_i)); // R1

    AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !wr_en_i && secs >= SEC_W'(LAST_SEC))
        |=> (secs == '0) && (day_i == DAY_W'($past(day_i) + 1'b1))); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !wr_en_i) |=> $stable(secs) && $stable(day_i)); // R1

    AST_DAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !wr_en_i && secs >= SEC_W'(LAST_SEC) && day_i == '1)
        |=> (day_i == '0) && ovf_sts_i); // R5

    AST_WR_OVER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == A_LO) |=> (lo_i == $past(lo_data_i))); // R4

    AST_TICK_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> tick_sts_i); // R7

    AST_TICK_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && tick_en_i && !(wr_en_i && addr_i == A_EN)) |=> irq_o); // R9
endmodule

bind tod_rtc tod_rtc_chk #(
    .DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W), .SEC_PER_DAY(SEC_PER_DAY)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .lo_data_i(wr_data_i[LO_W-1:0]), .irq_o(irq_o),
    .day_i(day_w), .lo_i(lo_w), .hi_i(hi_w),
    .tick_sts_i(sts_w[tod_rtc_pkg::ST_TICK]),
    .ovf_sts_i(sts_w[tod_rtc_pkg::ST_OVF]),
    .tick_en_i(en_w[tod_rtc_pkg::ST_TICK])
);

// File: tb/tod_rtc_tb_top.sv
`timescale 1ns/100ps
module tod_rtc_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of the register file
    int unsigned m_day, m_lo, m_hi, a_day, a_lo, a_hi, m_sts, m_en;
    bit m_hit;

    always #4 clk_i = ~clk_i;

    tod_rtc dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o)
    );

    function automatic void model_reset();
        m_day = 0; m_lo = 0; m_hi = 0; a_day = 0; a_lo = 0; a_hi = 0;
        m_sts = 0; m_en = 0; m_hit = 1;
    endfunction

    function automatic void model_edge(bit t, bit w, int unsigned a, int unsigned d);
        int unsigned secs, nsecs, nday, clr, ev;
        bit hit;
        hit   = (m_day == a_day) && (m_lo == a_lo) && (m_hi == a_hi);
        ev    = (hit && !m_hit) ? 1 : 0;        // R6
        m_hit = hit;
        secs  = m_hi * 256 + m_lo;
        nsecs = secs;
        nday  = m_day;
        clr   = 0;
        if (t) begin
            ev |= 2;                              // R7
            if (secs >= 86399) begin              // R1
                nsecs = 0;
                nday  = (m_day + 1) % 32768;
                if (m_day == 32767) ev |= 4;      // R5
            end else nsecs = secs + 1;
        end
        m_day = nday; m_lo = nsecs % 256; m_hi = nsecs / 256;
        if (w) begin                              // R3 masking, R4 priority
            case (a)
                0: m_day = d & 16'h7fff;
                1: m_lo  = d & 16'h00ff;
                2: m_hi  = d & 16'h01ff;
                3: a_day = d & 16'h7fff;
                4: a_lo  = d & 16'h00ff;
                5: a_hi  = d & 16'h01ff;
                6: clr   = d & 7;
                default: m_en = d & 7;
            endcase
        end
        m_sts = (m_sts & ~clr & 7) | ev;          // R8
    endfunction

    function automatic int unsigned model_reg(int unsigned a);
        case (a)
            0: return m_day;
            1: return m_lo;
            2: return m_hi;
            3: return a_day;
            4: return a_lo;
            5: return a_hi;
            6: return m_sts;
            default: return m_en;
        endcase
    endfunction

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(int unsigned a, output int unsigned v);
        addr_i = a[2:0];
        #0.1;
        v = rd_data_o;
    endtask

    // one clock cycle; returns at the next falling edge with idle inputs
    task automatic cyc(bit t, bit w, int unsigned a, int unsigned d);
        tick_i = t; wr_en_i = w; addr_i = a[2:0]; wr_data_i = d[15:0];
        @(posedge clk_i);
        model_edge(t, w, a, d);
        @(negedge clk_i);
        tick_i = 0; wr_en_i = 0; wr_data_i = '0;
    endtask

    task automatic wr(int unsigned a, int unsigned d);
        cyc(0, 1, a, d);
    endtask

    task automatic check_all(string tag);
        int unsigned v;
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            chk($sformatf("%s R2 reg%0d", tag, a), v, model_reg(a));
        end
        chk($sformatf("%s R9 irq", tag), irq_o, ((m_sts & m_en) != 0) ? 1 : 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned v, h1, h2, dd, ll;
        void'($urandom(32'h5eed_0c1d));
        model_reset();
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        @(negedge clk_i);
        // R11 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            chk("R11 reset reg", v, 0);
        end
        chk("R11 reset irq", irq_o, 0);

        // R3 masking on time fields
        wr(0, 16'hffff); rd(0, v); chk("R3 day mask", v, 16'h7fff);
        wr(1, 16'hffff); rd(1, v); chk("R3 lo mask", v, 16'h00ff);
        wr(2, 16'hffff); rd(2, v); chk("R3 hi mask", v, 16'h01ff);
        // out-of-range seconds and max day: one tick wraps both (R1, R5)
        cyc(1, 0, 0, 0);
        rd(0, v); chk("R5 day wraps to 0", v, 0);
        rd(1, v); chk("R1 lo after wrap", v, 0);
        rd(2, v); chk("R1 hi after wrap", v, 0);
        rd(6, v); chk("R5 wrap status bit2", v & 4, 4);
        check_all("R5");

        // R1 end of day 86399 = hi 0x151 lo 0x7f
        wr(0, 5); wr(2, 16'h151); wr(1, 16'h7f);
        cyc(1, 0, 0, 0);
        rd(0, v); chk("R1 day+1 at wrap", v, 6);
        rd(1, v); chk("R1 lo zero at wrap", v, 0);
        rd(2, v); chk("R1 hi zero at wrap", v, 0);
        cyc(1, 0, 0, 0);
        rd(1, v); chk("R1 step after wrap", v, 1);
        wr(2, 3); wr(1, 16'hff); cyc(1, 0, 0, 0);
        rd(2, v); chk("R1 carry into hi", v, 4);
        rd(1, v); chk("R1 lo after carry", v, 0);
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        rd(1, v); chk("R1 hold without tick", v, 0);

        // R4 write on a tick cycle
        wr(0, 2); wr(2, 3); wr(1, 16'hff);
        cyc(1, 1, 1, 16'h10);
        rd(1, v); chk("R4 written lo wins", v, 16'h10);
        rd(2, v); chk("R4 hi still carries", v, 4);
        wr(0, 9); wr(2, 16'h151); wr(1, 16'h7f);
        cyc(1, 1, 2, 7);
        rd(2, v); chk("R4 written hi wins", v, 7);
        rd(1, v); chk("R4 lo still wraps", v, 0);
        rd(0, v); chk("R4 day still advances", v, 10);

        // R10 ordered set across ticks
        wr(1, 0); cyc(1, 0, 0, 0);
        wr(0, 100); cyc(1, 0, 0, 0);
        wr(2, 16'h80); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
        wr(1, 16'h20);
        rd(0, v); chk("R10 set day", v, 100);
        rd(2, v); chk("R10 set hi", v, 16'h80);
        rd(1, v); chk("R10 set lo", v, 16'h20);
        // R10 ordered read with a carry between reads
        wr(0, 7); wr(2, 16'h151); wr(1, 16'h7f);
        rd(2, h1);
        cyc(1, 0, 0, 0);
        rd(0, dd); rd(1, ll); rd(2, h2);
        chk("R10 second hi below first", (h2 < h1) ? 1 : 0, 1);
        rd(0, dd);
        chk("R10 reread day", dd, 8);
        chk("R10 live lo", ll, 0);
        check_all("R10");

        // R6 alarm edge, R8 clear
        wr(3, 3); wr(5, 0); wr(4, 5);
        wr(0, 3); wr(2, 0); wr(1, 3);
        wr(6, 7);
        rd(6, v); chk("R8 cleared all", v, 0);
        cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
        rd(6, v); chk("R6 not yet set", v & 1, 0);
        cyc(0, 0, 0, 0);
        rd(6, v); chk("R6 alarm set", v & 1, 1);
        wr(6, 1);
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        rd(6, v); chk("R6 no re-set while equal", v & 1, 0);
        check_all("R6");

        // R9 interrupt merge, R8 set beats clear
        wr(6, 7); wr(7, 2);
        chk("R9 irq low no status", irq_o, 0);
        cyc(1, 0, 0, 0);
        chk("R9 irq on tick", irq_o, 1);
        cyc(1, 1, 6, 2);
        rd(6, v); chk("R8 tick wins over clear", v & 2, 2);
        wr(6, 2);
        chk("R9 irq low after clear", irq_o, 0);
        wr(7, 0); cyc(1, 0, 0, 0);
        chk("R9 masked tick", irq_o, 0);
        rd(6, v); chk("R7 tick status", v & 2, 2);

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            bit t, w;
            int unsigned a, d;
            t = ($urandom % 4) == 0;
            w = ($urandom % 3) == 0;
            a = $urandom % 8;
            d = $urandom;
            if (a == 2 && ($urandom % 2)) d = 16'h151;
            if (a == 1 && ($urandom % 2)) d = 16'h7e + ($urandom % 3);
            cyc(t, w, a, d);
            check_all("rand");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule